// File: doc/BRIEF.md
# DMA Channel Transfer-Request and Bus-Hold Sequencer

This block decides when a single DMA channel asks for the system bus, how many transfer units it performs once the bus is granted, and when it hands the bus back. A unit is one read cycle followed by one write cycle. Address generation and data movement are done elsewhere; this block only drives the bus request, the read and write phase flags and an active-low end-of-transfer marker.

Activation comes from one of two sources. With the external source, an active-low request pin is used, and it can be sensed in three ways:
- on its falling edge, where each edge starts one unit;
- on its low level, where units run while the pin stays low;
- on its falling edge in block mode, where each edge moves a whole block of units.

With the internal source, the transfer starts as soon as the channel is enabled. It then runs in one of two ways:
- cycle-steal, where the bus is released after every unit;
- burst, where the bus is held until the count is done, but is given up after the current unit whenever a higher-priority bus request is present.

The unit count and block size are taken while the channel is disabled. The configuration inputs are expected to stay steady while the channel is enabled.

Top module: `dma_req_seq`

## Requirements
- R1: After reset, and whenever no unit is in progress, bus_req, xfer_rd and xfer_wr are 0 and end_n is 1.
- R2: end_oe equals ext_sel, so the end marker is driven whenever external activation is selected; the request pin is input-only.
- R3: With the channel idle and external edge sensing selected, bus_req rises exactly three rising clock edges after the clock edge at which dreq_n was driven low (two synchronizer stages plus one state register), given an immediate grant.
- R4: In external edge mode with blk_mode=0, each falling edge of dreq_n starts exactly one unit. A falling edge that the synchronizer presents while a unit is already running is discarded.
- R5: In external level mode (lvl_sense=1, blk_mode=0), units repeat while dreq_n is low until the count is exhausted. bus_req drops for at least one cycle between units.
- R6: Once a level request has started a unit, that unit completes even if dreq_n returns high. No further unit starts until dreq_n is low again.
- R7: In external block mode, lvl_sense is ignored and only falling edges act. Each edge moves min(blk_size, remaining) units with bus_req held high throughout.
- R8: end_n is 0 only during the write cycle of the unit that brings the remaining count to zero, and in block mode also during the last write of each block.
- R9: With internal activation and burst_sel=0 (cycle-steal), units start as soon as chan_en is 1, and bus_req drops between every pair of units.
- R10: With internal activation and burst_sel=1, bus_req stays high across all units. If hp_req is 1 during a write, the bus is released after that unit, and the transfer resumes once hp_req is 0.
- R11: Every unit is one xfer_rd cycle immediately followed by one xfer_wr cycle; the count decrements after the write. A unit_count of 0 produces no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; counts load while 0 and the channel is idle |
| ext_sel | input | 1 | 1 = external request pin, 0 = internal activation |
| blk_mode | input | 1 | 1 = block mode (external activation only) |
| lvl_sense | input | 1 | 1 = level sensing, 0 = edge sensing (external, non-block) |
| burst_sel | input | 1 | Internal activation: 1 = burst, 0 = cycle-steal |
| unit_count | input | CNT_W | Number of units to transfer |
| blk_size | input | BLK_W | Units per block (0 treated as 1) |
| dreq_n | input | 1 | Active-low external request pin, asynchronous |
| hp_req | input | 1 | Higher-priority bus request |
| bus_grant | input | 1 | Bus grant handshake |
| bus_req | output | 1 | Bus request, held while the channel owns the bus |
| xfer_rd | output | 1 | Read phase of a unit |
| xfer_wr | output | 1 | Write phase of a unit |
| end_n | output | 1 | Active-low end-of-transfer marker |
| end_oe | output | 1 | Output enable for the end-of-transfer pin |

## Verification
Request edges reach bus_req on the third rising edge after they are driven. Each unit then shows xfer_rd for one cycle and xfer_wr in the next, and end_n is read in that write cycle. The bench samples every output at the falling clock edge, so each result is taken in the cycle it becomes valid. A driver pushes the expected end marker of each unit into a queue, and a monitor pops one entry for each write cycle it sees. Rising edges of bus_req are counted for each scenario, which separates burst, cycle-steal and block bus-holding. After a quiet period the queue must be empty, which catches both missing and extra units.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_RD   = 2'd2,
      ST_WR   = 2'd3
   } seq_state_t;

   typedef struct packed {
      logic ext;     // external request source
      logic blk;     // block mode in effect
      logic lvl;     // level sensing in effect
      logic burst;   // internal burst mode in effect
   } act_mode_t;

   function automatic act_mode_t decode_mode(input logic ext_sel, input logic blk_mode,
                                             input logic lvl_sense, input logic burst_sel);
      act_mode_t m;
      m.ext   = ext_sel;
      m.blk   = ext_sel & blk_mode;
      m.lvl   = ext_sel & lvl_sense & ~blk_mode;
      m.burst = ~ext_sel & burst_sel;
      return m;
   endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic low_lvl,
   output logic fall_evt
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("dma_req_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;
   logic          prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b1;
            else        chain_q[0] <= pin_n;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[LAST];
   end

   assign low_lvl  = ~chain_q[LAST];
   assign fall_evt = prev_q & ~chain_q[LAST];

endmodule

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
   import dma_seq_pkg::*;
(
   input  act_mode_t mode,
   input  logic      chan_en,
   input  logic      active,
   input  logic      idle,
   input  logic      hp_req,
   input  logic      low_lvl,
   input  logic      fall_evt,
   output logic      start
);
   logic trig;

   always_comb begin
      if (!mode.ext)     trig = ~(mode.burst & hp_req);
      else if (mode.lvl) trig = low_lvl;
      else               trig = fall_evt;
   end

   // Edges or levels seen while a unit or block runs are not queued.
   assign start = idle & chan_en & active & trig;

endmodule

// File: rtl/dma_unit_cnt.sv
module dma_unit_cnt #(
   parameter int CNT_W = 16,
   parameter int BLK_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] unit_count,
   input  logic             blk_start,
   input  logic [BLK_W-1:0] blk_size,
   input  logic             dec,
   output logic             active,
   output logic             last_all,
   output logic             last_blk,
   output logic [CNT_W-1:0] remaining
);
   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
   localparam logic [BLK_W-1:0] ONE_B = BLK_W'(1);

   if (CNT_W < 2 || BLK_W < 1) begin : g_bad_width
      $error("dma_unit_cnt: CNT_W must be >= 2 and BLK_W >= 1");
   end

   logic [CNT_W-1:0] rem_q;
   logic [BLK_W-1:0] blk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rem_q <= '0;
      else if (load) rem_q <= unit_count;
      else if (dec)  rem_q <= rem_q - ONE_C;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         blk_q <= '0;
      else if (blk_start) blk_q <= blk_size;
      else if (dec)       blk_q <= blk_q - ONE_B;
   end

   assign active    = (rem_q != '0);
   assign last_all  = (rem_q == ONE_C);
   assign last_blk  = (blk_q <= ONE_B);
   assign remaining = rem_q;

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (rem_q != '0)); // R11

endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
   import dma_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  act_mode_t mode,
   input  logic      start,
   input  logic      bus_grant,
   input  logic      hp_req,
   input  logic      last_all,
   input  logic      last_blk,
   output logic      idle,
   output logic      bus_req,
   output logic      xfer_rd,
   output logic      xfer_wr,
   output logic      end_n
);
   seq_state_t st_q, st_d;
   logic       keep_bus;

   // Decide, during the write, whether the next unit follows without a release.
   always_comb begin
      keep_bus = 1'b0;
      if (!last_all) begin
         if (mode.blk)                  keep_bus = ~last_blk;
         else if (mode.burst && !hp_req) keep_bus = 1'b1;
      end
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (start)     st_d = ST_REQ;
         ST_REQ:  if (bus_grant) st_d = ST_RD;
         ST_RD:                  st_d = ST_WR;
         ST_WR:                  st_d = keep_bus ? ST_RD : ST_IDLE;
         default:                st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign idle    = (st_q == ST_IDLE);
   assign bus_req = (st_q != ST_IDLE);
   assign xfer_rd = (st_q == ST_RD);
   assign xfer_wr = (st_q == ST_WR);
   assign end_n   = ~((st_q == ST_WR) & (last_all | (mode.blk & last_blk)));

   AST_RD_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RD) |-> $past(bus_grant)); // R11

endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
   import dma_seq_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int BLK_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             ext_sel,
   input  logic             blk_mode,
   input  logic             lvl_sense,
   input  logic             burst_sel,
   input  logic [CNT_W-1:0] unit_count,
   input  logic [BLK_W-1:0] blk_size,
   input  logic             dreq_n,
   input  logic             hp_req,
   input  logic             bus_grant,
   output logic             bus_req,
   output logic             xfer_rd,
   output logic             xfer_wr,
   output logic             end_n,
   output logic             end_oe
);
   act_mode_t        mode;
   logic             low_lvl, fall_evt;
   logic             idle, start, active, last_all, last_blk;
   logic [CNT_W-1:0] remaining;

   assign mode   = decode_mode(ext_sel, blk_mode, lvl_sense, burst_sel);
   assign end_oe = ext_sel;

   dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n    (dreq_n),
      .low_lvl  (low_lvl),
      .fall_evt (fall_evt)
   );

   dma_trig_sel u_trig (
      .mode     (mode),
      .chan_en  (chan_en),
      .active   (active),
      .idle     (idle),
      .hp_req   (hp_req),
      .low_lvl  (low_lvl),
      .fall_evt (fall_evt),
      .start    (start)
   );

   dma_unit_cnt #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (idle & ~chan_en),
      .unit_count (unit_count),
      .blk_start  (start),
      .blk_size   (blk_size),
      .dec        (xfer_wr),
      .active     (active),
      .last_all   (last_all),
      .last_blk   (last_blk),
      .remaining  (remaining)
   );

   dma_bus_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .start     (start),
      .bus_grant (bus_grant),
      .hp_req    (hp_req),
      .last_all  (last_all),
      .last_blk  (last_blk),
      .idle      (idle),
      .bus_req   (bus_req),
      .xfer_rd   (xfer_rd),
      .xfer_wr   (xfer_wr),
      .end_n     (end_n)
   );

   AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_wr |-> $past(xfer_rd)); // R11
   AST_END_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (!end_n && !mode.blk) |=> (remaining == '0)); // R8
   AST_HP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_wr && hp_req && !mode.blk) |=> !xfer_rd); // R10
   AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_wr && end_n && mode.blk) |=> xfer_rd); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |-> (!xfer_rd && !xfer_wr && end_n)); // R1

endmodule

// File: tb/dma_req_seq_tb.sv
module dma_req_seq_tb;
   localparam int CNT_W = 16;
   localparam int BLK_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             chan_en = 1'b0, ext_sel = 1'b0, blk_mode = 1'b0;
   logic             lvl_sense = 1'b0, burst_sel = 1'b0;
   logic [CNT_W-1:0] unit_count = '0;
   logic [BLK_W-1:0] blk_size = '0;
   logic             dreq_n = 1'b1, hp_req = 1'b0;
   logic             bus_grant;
   logic             bus_req, xfer_rd, xfer_wr, end_n, end_oe;

   int checks = 0;
   int errors = 0;
   int rises = 0;
   bit done = 1'b0;
   bit exp_q[$];

   always #10 clk = ~clk;
   assign bus_grant = bus_req;

   dma_req_seq #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .ext_sel(ext_sel),
      .blk_mode(blk_mode), .lvl_sense(lvl_sense), .burst_sel(burst_sel),
      .unit_count(unit_count), .blk_size(blk_size), .dreq_n(dreq_n),
      .hp_req(hp_req), .bus_grant(bus_grant), .bus_req(bus_req),
      .xfer_rd(xfer_rd), .xfer_wr(xfer_wr), .end_n(end_n), .end_oe(end_oe)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // Driver side of the scoreboard: one entry per expected unit (1 = end marker).
   task automatic push(input bit last);
      exp_q.push_back(last);
   endtask

   // Monitor: sampled at the falling edge, pops one entry per write cycle.
   logic prev_req = 1'b0;
   logic prev_rd  = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_req && !prev_req) rises++;
         if (xfer_wr) begin
            check("R11 read precedes write", int'(prev_rd), 1);
            if (exp_q.size() == 0) begin
               check("R4 unexpected unit", 1, 0);
            end else begin
               check("R8 end marker on write", int'(!end_n), int'(exp_q.pop_front()));
            end
         end else if (!end_n) begin
            check("R8 end marker outside write", 1, 0);
         end
         prev_req = bus_req;
         prev_rd  = xfer_rd;
      end
   end

   task automatic idle_cfg(input bit ext, input bit blk, input bit lvl, input bit bst,
                           input int cnt, input int bsz);
      @(negedge clk);
      chan_en = 1'b0; dreq_n = 1'b1; hp_req = 1'b0;
      ext_sel = ext; blk_mode = blk; lvl_sense = lvl; burst_sel = bst;
      unit_count = CNT_W'(cnt); blk_size = BLK_W'(bsz);
      repeat (4) @(negedge clk);
      chan_en = 1'b1;
   endtask

   task automatic settle(input string req, input int r0, input int exp_rises);
      repeat (20) @(negedge clk);
      check({req, " queue drained"}, exp_q.size(), 0);
      check({req, " bus request count"}, rises - r0, exp_rises);
   endtask

   task automatic fall_edge();
      dreq_n = 1'b1;
      repeat (3) @(negedge clk);
      dreq_n = 1'b0;
   endtask

   initial begin
      int r0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 bus_req", int'(bus_req), 0);
      check("R1 xfer_rd", int'(xfer_rd), 0);
      check("R1 xfer_wr", int'(xfer_wr), 0);
      check("R1 end_n", int'(end_n), 1);
      check("R2 end_oe internal", int'(end_oe), 0);

      // R9 cycle-steal, 3 units, three separate bus requests
      r0 = rises; push(0); push(0); push(1);
      idle_cfg(0, 0, 0, 0, 3, 1);
      settle("R9", r0, 3);

      // R10 burst, 4 units, one bus request
      r0 = rises; push(0); push(0); push(0); push(1);
      idle_cfg(0, 0, 0, 1, 4, 1);
      settle("R10", r0, 1);

      // R10 burst with a higher-priority request after the first unit
      r0 = rises; push(0); push(0); push(0); push(1);
      idle_cfg(0, 0, 0, 1, 4, 1);
      while (!xfer_wr) @(negedge clk);
      hp_req = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 bus released under hp_req", int'(bus_req), 0);
      hp_req = 1'b0;
      settle("R10 hp", r0, 2);

      // R11 zero count: nothing happens
      r0 = rises;
      idle_cfg(0, 0, 0, 0, 0, 1);
      settle("R11 zero count", r0, 0);

      // R3/R4 edge mode, count 2, with exact latency
      r0 = rises; push(0);
      idle_cfg(1, 0, 0, 0, 2, 1);
      check("R2 end_oe external", int'(end_oe), 1);
      dreq_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R3 bus_req before third edge", int'(bus_req), 0);
      @(negedge clk);
      check("R3 bus_req at third edge", int'(bus_req), 1);
      settle("R4 first edge", r0, 1);
      r0 = rises; push(1);
      fall_edge();
      settle("R4 second edge", r0, 1);
      r0 = rises;
      fall_edge();
      settle("R4 count exhausted", r0, 0);

      // R4 edge arriving during a running unit is dropped
      r0 = rises; push(0);
      idle_cfg(1, 0, 0, 0, 3, 1);
      dreq_n = 1'b0;
      @(negedge clk); dreq_n = 1'b1;
      @(negedge clk); dreq_n = 1'b0;
      settle("R4 dropped edge", r0, 1);

      // R5 level mode, held low, 3 units with release between
      r0 = rises; push(0); push(0); push(1);
      idle_cfg(1, 0, 1, 0, 3, 1);
      dreq_n = 1'b0;
      settle("R5 level", r0, 3);

      // R6 one-cycle low pulse completes one unit, then suspends
      r0 = rises; push(0);
      idle_cfg(1, 0, 1, 0, 3, 1);
      dreq_n = 1'b0;
      @(negedge clk); dreq_n = 1'b1;
      settle("R6 latched unit", r0, 1);
      r0 = rises; push(0); push(1);
      dreq_n = 1'b0;
      settle("R6 resume", r0, 2);

      // R7 block mode, level select ignored, count 5 in blocks of 2
      r0 = rises; push(0); push(1);
      idle_cfg(1, 1, 1, 0, 5, 2);
      dreq_n = 1'b0;
      settle("R7 block one", r0, 1);
      r0 = rises; push(0); push(1);
      fall_edge();
      settle("R7 block two", r0, 1);
      r0 = rises; push(1);
      fall_edge();
      settle("R7 short tail", r0, 1);
      r0 = rises;
      fall_edge();
      settle("R7 exhausted", r0, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule